// File: doc/BRIEF.md
# Generation-Bit Completion Ring Reader

This block is the consumer end of a completion ring kept in local memory. A producer writes 64-bit completion entries into a ring of 2^RING_LOG2 slots and never shares its write position with the reader. Instead, each entry carries a generation bit in its 32-bit header (the low word of the entry). The reader keeps a free-running read pointer one bit wider than the slot index. It treats a slot as fresh only when that header bit equals the inverse of the pointer's wrap bit, so on the first trip around the ring it expects 1, and on the second trip it expects 0.

A small overflow queue, filled through a push port, sits beside the ring and always wins. While it holds anything, its head entry is presented and the ring is not consulted. The selected entry is held in an output register behind a valid/ready handshake, together with the decoded header fields and a flag for the send-type opcodes. The single memory read port has a fixed one-cycle latency. While the reader has nothing to present, it alternates between reading the ring slot at its read index and reading the error word stored just past the last slot, at index 2^RING_LOG2. It shows whether that word is nonzero on a status output.

Top module: `cq_reader`

## Requirements
- R1: After reset, out_valid_o, err_o and sw_full_o are 0, and the first memory read targets address 0.
- R2: A ring slot is presented only when header bit 10 equals the inverse of read pointer bit RING_LOG2; on the first trip a slot whose bit 10 is 0 is never presented.
- R3: After the read pointer wraps past the last slot, entries with header bit 10 = 1 are stale and entries with bit 10 = 0 are presented.
- R4: While the overflow queue is non-empty, its entries are presented first in push order, with out_from_sw_o = 1; ring entries follow only once it is empty. An overflow entry pushed into an idle reader is valid after the second rising edge following the push.
- R5: The overflow queue reports full (sw_full_o = 1) when it holds 2^SWQ_LOG2 entries, counting the one being presented; a push while full is dropped and never presented.
- R6: The header decodes as follows: bit 31 is out-of-order, bits 30:12 are the queue-pair id, bit 11 is the software flag, bit 10 is the generation bit, bits 9:5 are the status, bit 4 is the type (1 = send queue) and bits 3:0 are the opcode.
- R7: out_is_send_o is 1 exactly for opcodes 3, 4, 5 and 6.
- R8: While out_valid_o = 1 and out_ready_i = 0, the entry and its source hold steady. A handshake consumes exactly one entry and advances the supplying read pointer by one.
- R9: err_o follows whether the low 32 bits of the word at index 2^RING_LOG2 are nonzero; the upper 32 bits of that word are ignored.
- R10: While idle, the read port alternates between the ring slot at the read index and the error word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | RING_LOG2+1 | Read word index (slot, or 2^RING_LOG2 for the error word) |
| mem_rdata_i | input | 64 | Read data, one cycle after the request |
| sw_push_i | input | 1 | Push an entry into the overflow queue |
| sw_entry_i | input | 64 | Entry to push |
| sw_full_o | output | 1 | Overflow queue full |
| out_valid_o | output | 1 | Presented entry valid |
| out_ready_i | input | 1 | Consumer accepts the entry |
| out_entry_o | output | 64 | Presented entry |
| out_from_sw_o | output | 1 | Entry came from the overflow queue |
| out_ooo_o | output | 1 | Out-of-order flag |
| out_qpid_o | output | 19 | Queue-pair id |
| out_swcqe_o | output | 1 | Software-generated flag |
| out_gen_o | output | 1 | Generation bit |
| out_status_o | output | 5 | Status |
| out_is_sq_o | output | 1 | Send-queue completion |
| out_opcode_o | output | 4 | Opcode |
| out_is_send_o | output | 1 | Opcode is a send variant |
| err_o | output | 1 | Ring error word is nonzero |

## Verification
An overflow entry pushed into an idle reader becomes visible after exactly the second rising edge, so the bench samples out_valid_o at both the first and the second falling edge after the push. A fresh ring entry becomes visible after two or three rising edges, depending on whether the alternating read port is on its slot phase or its error phase when the entry is written. A change to the error word reaches err_o on the same schedule. For these ring-side results, the bench polls at falling edges within a bounded window and then compares the values. Stale-entry and dropped-push checks watch out_valid_o stay low for ten cycles, which covers several full slot/error read rounds.

// File: rtl/cqr_pkg.sv
package cqr_pkg;
  localparam int ENTRY_W = 64;
  localparam int HDR_W   = 32;
  localparam int QPID_W  = 19;
  localparam int STAT_W  = 5;
  localparam int OP_W    = 4;
  localparam int GEN_BIT = 10;

  typedef struct packed {
    logic              ooo;
    logic [QPID_W-1:0] qpid;
    logic              swcqe;
    logic              gen;
    logic [STAT_W-1:0] status;
    logic              is_sq;
    logic [OP_W-1:0]   opcode;
  } cq_hdr_t;

  localparam logic [OP_W-1:0] OP_SEND_LO = 4'd3;
  localparam logic [OP_W-1:0] OP_SEND_HI = 4'd6;
endpackage

// File: rtl/cqr_hdr_decode.sv
module cqr_hdr_decode
  import cqr_pkg::*;
(
  input  logic [HDR_W-1:0]  hdr_i,
  output logic              ooo_o,
  output logic [QPID_W-1:0] qpid_o,
  output logic              swcqe_o,
  output logic              gen_o,
  output logic [STAT_W-1:0] status_o,
  output logic              is_sq_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic              is_send_o
);
  cq_hdr_t h;

  always_comb begin
    h         = cq_hdr_t'(hdr_i);
    ooo_o     = h.ooo;
    qpid_o    = h.qpid;
    swcqe_o   = h.swcqe;
    gen_o     = h.gen;
    status_o  = h.status;
    is_sq_o   = h.is_sq;
    opcode_o  = h.opcode;
    is_send_o = (h.opcode >= OP_SEND_LO) && (h.opcode <= OP_SEND_HI);
  end
endmodule

// File: rtl/cqr_swq.sv
module cqr_swq #(
  parameter int DW   = 64,
  parameter int LOG2 = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [DW-1:0] head_o
);
  localparam int DEPTH = 1 << LOG2;
  localparam int PW    = LOG2 + 1;

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [PW-1:0] used;
  logic          do_push;

  assign used    = wptr_q - rptr_q;
  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = ((used >> LOG2) != '0) && (wptr_q != rptr_q);
  assign do_push = push_i && !full_o;
  assign head_o  = store_q[rptr_q[LOG2-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (pop_i && !empty_o) rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wptr_q[LOG2-1:0]] <= data_i;
  end

  // R5: a push into a full queue leaves the write side untouched
  a_r5_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(wptr_q));
endmodule

// File: rtl/cqr_hw_fetch.sv
module cqr_hw_fetch
  import cqr_pkg::*;
#(
  parameter int RING_LOG2 = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fetch_en_i,
  input  logic                 pop_i,
  input  logic [HDR_W-1:0]     hdr_i,
  output logic                 mem_req_o,
  output logic [RING_LOG2:0]   mem_addr_o,
  output logic                 hit_o,
  output logic                 err_o
);
  localparam int AW    = RING_LOG2 + 1;
  localparam int SLOTS = 1 << RING_LOG2;
  localparam logic [AW-1:0] ERR_ADDR = AW'(SLOTS);

  logic [AW-1:0] rptr_q;
  logic          poll_err_q;
  logic          pend_q, pend_err_q;
  logic          err_q;
  logic          exp_gen;

  assign exp_gen    = ~rptr_q[RING_LOG2];
  assign mem_req_o  = fetch_en_i;
  assign mem_addr_o = poll_err_q ? ERR_ADDR : {1'b0, rptr_q[RING_LOG2-1:0]};
  assign hit_o      = pend_q && !pend_err_q && (hdr_i[GEN_BIT] == exp_gen);
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q     <= '0;
      poll_err_q <= 1'b0;
      pend_q     <= 1'b0;
      pend_err_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      pend_q <= mem_req_o;
      if (mem_req_o) begin
        pend_err_q <= poll_err_q;
        poll_err_q <= ~poll_err_q;
      end
      if (pend_q && pend_err_q) err_q <= |hdr_i;
      if (pop_i) rptr_q <= rptr_q + 1'b1;
    end
  end

  // R8: each consumed ring entry advances the read pointer by one
  a_r8_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> rptr_q == $past(rptr_q) + 1'b1);

  // R9: the status flag moves only when an error-word read returns
  a_r9_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && pend_err_q) |=> $stable(err_q));
endmodule

// File: rtl/cq_reader.sv
module cq_reader
  import cqr_pkg::*;
#(
  parameter int RING_LOG2 = 3,
  parameter int SWQ_LOG2  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                mem_req_o,
  output logic [RING_LOG2:0]  mem_addr_o,
  input  logic [63:0]         mem_rdata_i,
  input  logic                sw_push_i,
  input  logic [63:0]         sw_entry_i,
  output logic                sw_full_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [63:0]         out_entry_o,
  output logic                out_from_sw_o,
  output logic                out_ooo_o,
  output logic [18:0]         out_qpid_o,
  output logic                out_swcqe_o,
  output logic                out_gen_o,
  output logic [4:0]          out_status_o,
  output logic                out_is_sq_o,
  output logic [3:0]          out_opcode_o,
  output logic                out_is_send_o,
  output logic                err_o
);
  logic               sw_empty;
  logic [ENTRY_W-1:0] sw_head;
  logic               hw_hit;
  logic               fetch_en, load_sw, load_hw;
  logic               pop, sw_pop, hw_pop;

  logic               out_valid_q;
  logic [ENTRY_W-1:0] out_entry_q;
  logic               out_sw_q;

  assign fetch_en = !out_valid_q && sw_empty;
  assign load_sw  = !out_valid_q && !sw_empty;
  assign load_hw  = fetch_en && hw_hit;
  assign pop      = out_valid_q && out_ready_i;
  assign sw_pop   = pop && out_sw_q;
  assign hw_pop   = pop && !out_sw_q;

  cqr_swq #(.DW(ENTRY_W), .LOG2(SWQ_LOG2)) u_swq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sw_push_i),
    .data_i  (sw_entry_i),
    .pop_i   (sw_pop),
    .empty_o (sw_empty),
    .full_o  (sw_full_o),
    .head_o  (sw_head)
  );

  cqr_hw_fetch #(.RING_LOG2(RING_LOG2)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_en_i (fetch_en),
    .pop_i      (hw_pop),
    .hdr_i      (mem_rdata_i[HDR_W-1:0]),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .hit_o      (hw_hit),
    .err_o      (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_entry_q <= '0;
      out_sw_q    <= 1'b0;
    end else if (pop) begin
      out_valid_q <= 1'b0;
    end else if (load_sw) begin
      out_valid_q <= 1'b1;
      out_entry_q <= sw_head;
      out_sw_q    <= 1'b1;
    end else if (load_hw) begin
      out_valid_q <= 1'b1;
      out_entry_q <= mem_rdata_i;
      out_sw_q    <= 1'b0;
    end
  end

  assign out_valid_o   = out_valid_q;
  assign out_entry_o   = out_entry_q;
  assign out_from_sw_o = out_sw_q;

  cqr_hdr_decode u_dec (
    .hdr_i     (out_entry_q[HDR_W-1:0]),
    .ooo_o     (out_ooo_o),
    .qpid_o    (out_qpid_o),
    .swcqe_o   (out_swcqe_o),
    .gen_o     (out_gen_o),
    .status_o  (out_status_o),
    .is_sq_o   (out_is_sq_o),
    .opcode_o  (out_opcode_o),
    .is_send_o (out_is_send_o)
  );

  // R8: a stalled output holds its entry and source
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_q && !out_ready_i) |=> out_valid_q && $stable(out_entry_q) && $stable(out_sw_q));

  // R4: a ring entry is only taken when the overflow queue was empty
  a_r4_sw_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_valid_q) && !out_sw_q) |-> $past(sw_empty));
endmodule

// File: tb/cq_reader_bench.sv
module cq_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RL    = 3;
  localparam int SL    = 2;
  localparam int SLOTS = 1 << RL;
  localparam int WD    = 100000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mem_req;
  logic [RL:0]   mem_addr;
  logic [63:0]   mem_rdata = '0;
  logic          sw_push = 1'b0;
  logic [63:0]   sw_entry = '0;
  logic          sw_full;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [63:0]   out_entry;
  logic          out_from_sw, out_ooo, out_swcqe, out_gen, out_is_sq, out_is_send, err;
  logic [18:0]   out_qpid;
  logic [4:0]    out_status;
  logic [3:0]    out_opcode;

  logic [63:0]   mem [0:SLOTS];
  int            tests = 0;
  int            fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr];

  cq_reader #(.RING_LOG2(RL), .SWQ_LOG2(SL)) u_cq_reader (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .sw_push_i(sw_push), .sw_entry_i(sw_entry), .sw_full_o(sw_full),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_entry_o(out_entry),
    .out_from_sw_o(out_from_sw), .out_ooo_o(out_ooo), .out_qpid_o(out_qpid),
    .out_swcqe_o(out_swcqe), .out_gen_o(out_gen), .out_status_o(out_status),
    .out_is_sq_o(out_is_sq), .out_opcode_o(out_opcode), .out_is_send_o(out_is_send),
    .err_o(err)
  );

  function automatic logic [31:0] hdr(input logic ooo, input logic [18:0] qp, input logic swf,
                                      input logic gen, input logic [4:0] st, input logic sq,
                                      input logic [3:0] op);
    return {ooo, qp, swf, gen, st, sq, op};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (out_valid) begin got = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic pop_expect(input string req, input logic [63:0] exp, input logic exp_sw);
    bit got;
    wait_valid(got);
    chk(req, "valid", got, 1);
    chk(req, "entry", out_entry, exp);
    chk(req, "source", out_from_sw, exp_sw);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic quiet(input string req, input int n);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    chk(req, "no entry presented", seen, 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i <= SLOTS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "err", err, 0);
    chk("R1", "sw_full", sw_full, 0);
    chk("R1", "first read", {mem_req, 4'(mem_addr)}, {1'b1, 4'd0});
    @(negedge clk);
  endtask

  // R2 and R6: first trip expects generation 1
  task automatic t_first_pass;
    logic [63:0] e0, e1, e2;
    e0 = {32'h0000_0040, hdr(1'b1, 19'h5A5A5, 1'b0, 1'b1, 5'h13, 1'b1, 4'd0)};
    e1 = {32'h0000_0011, hdr(1'b0, 19'h00001, 1'b1, 1'b1, 5'h00, 1'b0, 4'd1)};
    e2 = {32'h0000_0022, hdr(1'b0, 19'h7FFFF, 1'b0, 1'b1, 5'h1F, 1'b0, 4'd2)};
    mem[0] = e0; mem[1] = e1; mem[2] = e2;
    begin
      bit got;
      wait_valid(got);
      chk("R6", "ooo", out_ooo, 1);
      chk("R6", "qpid", out_qpid, 19'h5A5A5);
      chk("R6", "swcqe", out_swcqe, 0);
      chk("R6", "gen", out_gen, 1);
      chk("R6", "status", out_status, 5'h13);
      chk("R6", "is_sq", out_is_sq, 1);
      chk("R6", "opcode", out_opcode, 0);
      chk("R7", "opcode 0 not send", out_is_send, 0);
    end
    pop_expect("R2", e0, 1'b0);
    pop_expect("R2", e1, 1'b0);
    pop_expect("R2", e2, 1'b0);
    quiet("R2 slot with gen 0 on first trip", 10);
  endtask

  // R7: opcodes 3..7 in slots 3..7
  task automatic t_send_ops;
    for (int k = 3; k < SLOTS; k++)
      mem[k] = {32'(k), hdr(1'b0, 19'(k), 1'b0, 1'b1, 5'd0, 1'b0, 4'(k))};
    for (int k = 3; k < SLOTS; k++) begin
      bit got;
      wait_valid(got);
      chk("R7", "is_send", out_is_send, (k >= 3 && k <= 6) ? 1 : 0);
      pop_expect("R7", mem[k], 1'b0);
    end
  endtask

  // R3 and R8: second trip, hold, single pop
  task automatic t_wrap_hold;
    logic [63:0] e;
    bit got;
    quiet("R3 stale gen 1 after wrap", 10);
    e = {32'h0000_0099, hdr(1'b0, 19'h00ABC, 1'b0, 1'b0, 5'h02, 1'b1, 4'd3)};
    mem[0] = e;
    wait_valid(got);
    chk("R3", "gen 0 presented after wrap", got, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8", "held entry", {out_valid, out_entry}, {1'b1, e});
    end
    pop_expect("R3", e, 1'b0);
    chk("R8", "single pop leaves output empty", out_valid, 0);
    quiet("R8 pointer advanced past popped slot", 10);
  endtask

  // R4: overflow entries go first
  task automatic t_priority;
    logic [63:0] h, s1, s2;
    h  = {32'h0000_00AA, hdr(1'b0, 19'h00111, 1'b0, 1'b0, 5'd0, 1'b0, 4'd8)};
    s1 = {32'h0000_00B1, hdr(1'b0, 19'h00222, 1'b1, 1'b0, 5'd1, 1'b1, 4'd4)};
    s2 = {32'h0000_00B2, hdr(1'b0, 19'h00333, 1'b1, 1'b1, 5'd2, 1'b0, 4'd5)};
    mem[1] = h;
    sw_push = 1'b1; sw_entry = s1;
    @(negedge clk);
    chk("R4", "not valid one edge after push", out_valid, 0);
    sw_entry = s2;
    @(negedge clk);
    sw_push = 1'b0;
    chk("R4", "valid two edges after push", out_valid, 1);
    pop_expect("R4", s1, 1'b1);
    pop_expect("R4", s2, 1'b1);
    pop_expect("R4", h, 1'b0);
  endtask

  // R5: full and dropped push
  task automatic t_full;
    logic [63:0] f [5];
    for (int i = 0; i < 5; i++) f[i] = {32'hF000_0000 + 32'(i), hdr(1'b0, 19'(i), 1'b1, 1'b0, 5'd0, 1'b0, 4'd9)};
    for (int i = 0; i < 4; i++) begin
      sw_push = 1'b1; sw_entry = f[i];
      @(negedge clk);
    end
    sw_push = 1'b0;
    chk("R5", "full at depth", sw_full, 1);
    sw_push = 1'b1; sw_entry = f[4];
    @(negedge clk);
    sw_push = 1'b0;
    for (int i = 0; i < 4; i++) pop_expect("R5", f[i], 1'b1);
    chk("R5", "not full after drain", sw_full, 0);
    quiet("R5 dropped push never presented", 10);
  endtask

  // R9 and R10: error word polling
  task automatic t_err;
    bit saw_err_addr = 1'b0, saw_slot_addr = 1'b0;
    bit got;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_req && mem_addr == (RL+1)'(SLOTS)) saw_err_addr = 1'b1;
      if (mem_req && mem_addr == (RL+1)'(2)) saw_slot_addr = 1'b1;
    end
    chk("R10", "reads alternate slot and error word", {saw_err_addr, saw_slot_addr}, 2'b11);
    mem[SLOTS] = 64'h0000_0001_0000_0000;
    repeat (6) @(negedge clk);
    chk("R9", "upper bits ignored", err, 0);
    mem[SLOTS] = 64'h0000_0000_0000_0001;
    got = 1'b0;
    for (int i = 0; i < 8 && !got; i++) begin
      @(negedge clk);
      if (err) got = 1'b1;
    end
    chk("R9", "err set", got, 1);
    mem[SLOTS] = '0;
    repeat (6) @(negedge clk);
    chk("R9", "err cleared", err, 0);
  endtask

  initial begin
    t_reset;
    t_first_pass;
    t_send_ops;
    t_wrap_hold;
    t_priority;
    t_full;
    t_err;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule